// File: doc/BRIEF.md
# Mantissa Reduction Unit

This block shortens an extended floating-point mantissa to its stored width. It takes the retained field, which includes the hidden leading one, together with two guard bits and a sticky bit. A two-bit mode input picks one of three reduction methods:

- plain chopping,
- jamming (von Neumann) rounding,
- round-half-up at the retained LSB.

The block is purely combinational. Its outputs are the reduced mantissa and a carry flag. The flag tells a downstream normalizer to shift right by one and bump the exponent.

A second input carries the raw bits that an alignment shifter pushed out below the guard bits. Any width of it may be connected. These bits are OR-folded with the sticky bit of the extended mantissa, so the shifter can feed the block without a reduction stage of its own.

Top module: `mant_reduce`

## Requirements
- R1: With mode 2'b00 (chop), `mant_out` equals the retained field `ext_in[W+2:3]` and `inc_carry` is 0, whatever the guard, sticky and tail bits are.
- R2: With mode 2'b01 (jam), `mant_out` equals the retained field with bit 0 forced to 1 when any of `ext_in[2]`, `ext_in[1]`, `ext_in[0]` or any `tail_in` bit is 1. Otherwise it equals the retained field. `inc_carry` is 0.
- R3: With mode 2'b10 (round), `mant_out` is the retained field plus one when `ext_in[2]` is 1. Otherwise it is the unchanged retained field. `ext_in[1]`, `ext_in[0]` and `tail_in` have no effect in this mode.
- R4: With mode 2'b10, an all-ones retained field and `ext_in[2]`=1, `mant_out` is a 1 in the MSB followed by zeros and `inc_carry` is 1.
- R5: `inc_carry` is 1 only in round mode when the increment carries out of the retained field.
- R6: Mode 2'b11 gives exactly the chop result.
- R7: The effective sticky bit is the OR of `ext_in[0]` and every bit of `tail_in`. A single set tail bit counts as nonzero discarded bits.
- R8: The bit positions in `ext_in` are fixed: `[W+2:3]` is the retained field, `[2]` is the high guard bit, `[1]` is the low guard bit and `[0]` is the sticky bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ext_in | input | W+3 | Extended mantissa: retained field, two guard bits, sticky bit |
| tail_in | input | TW | Extra shifted-out bits, OR-folded into the sticky bit |
| mode_sel | input | 2 | Reduction method: 00 chop, 01 jam, 10 round, 11 chop |
| mant_out | output | W | Reduced mantissa |
| inc_carry | output | 1 | Round increment carried out; normalizer must shift and adjust the exponent |

## Verification
The embedded checks rely on inputs that settle to known binary values before they are compared. They also rely on the mode code being one of the four two-bit values, with code 3 grouped with chop.

The stimulus keeps to this by changing inputs only just after a clock edge and comparing half a period later, so every check sees settled logic. A small instance with a three-bit field is driven through every ext, tail and mode combination. A full-width instance gets random vectors plus directed cases for the overflow pattern and lone tail bits.

// File: rtl/mr_pkg.sv
package mr_pkg;
  typedef enum logic [1:0] {
    MR_CHOP = 2'b00,
    MR_JAM  = 2'b01,
    MR_RND  = 2'b10,
    MR_RSVD = 2'b11
  } mr_mode_e;
endpackage

// File: rtl/mr_sticky.sv
// Folds an arbitrary-width shifted-out vector into the sticky bit (R7).
module mr_sticky #(
  parameter int TW = 8
) (
  input  logic [TW-1:0] tail_in,
  input  logic          low_bit,
  output logic          sticky
);
  logic tail_any;

  generate
    if (TW == 1) begin : g_single
      assign tail_any = tail_in[0];
    end else begin : g_wide
      assign tail_any = |tail_in;
    end
  endgenerate

  assign sticky = low_bit | tail_any;

  always_comb begin
    if (tail_any) p_tail_sets_sticky_r7: assert (sticky);
  end
endmodule

// File: rtl/mr_method.sv
// Applies the selected reduction method to the retained field.
module mr_method
  import mr_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0] field,
  input  logic         g_hi,
  input  logic         g_lo,
  input  logic         sticky,
  input  mr_mode_e     mode,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam logic [W-1:0] ONE_HOT_MSB = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES    = {W{1'b1}};

  // Named internal events, brought out for the checks.
  logic any_lost;
  logic rnd_inc;
  logic rnd_ovf;

  function automatic logic [W:0] f_chop(input logic [W-1:0] f);
    return {1'b0, f};
  endfunction

  function automatic logic [W:0] f_jam(input logic [W-1:0] f, input logic lost);
    logic [W-1:0] v;
    v = f;
    if (lost) v[0] = 1'b1;
    return {1'b0, v};
  endfunction

  function automatic logic [W:0] f_round(input logic [W-1:0] f, input logic inc);
    logic [W:0] s;
    s = {1'b0, f} + {{W{1'b0}}, inc};
    if (s[W]) return {1'b1, s[W:1]};
    return s;
  endfunction

  assign any_lost = g_hi | g_lo | sticky;
  assign rnd_inc  = (mode == MR_RND) & g_hi;
  assign rnd_ovf  = rnd_inc & (field == ALL_ONES);

  always_comb begin
    case (mode)
      MR_JAM:  {cout, res} = f_jam(field, any_lost);
      MR_RND:  {cout, res} = f_round(field, g_hi);
      default: {cout, res} = f_chop(field);
    endcase
  end

  always_comb begin
    if (mode == MR_CHOP || mode == MR_RSVD) begin
      p_chop_pass_r1: assert (res == field && !cout);
    end
    if (mode == MR_JAM && any_lost) begin
      p_jam_lsb_r2: assert (res[0] && res[W-1:1] == field[W-1:1] && !cout);
    end
    if (mode == MR_JAM && !any_lost) begin
      p_jam_clean_r2: assert (res == field);
    end
    if (mode == MR_RND && !g_hi) begin
      p_round_hold_r3: assert (res == field && !cout);
    end
    if (rnd_ovf) begin
      p_ovf_pattern_r4: assert (cout && res == ONE_HOT_MSB);
    end
    if (cout) begin
      p_cout_round_only_r5: assert (rnd_inc && field == ALL_ONES);
    end
  end
endmodule

// File: rtl/mant_reduce.sv
module mant_reduce
  import mr_pkg::*;
#(
  parameter int W  = 24,
  parameter int TW = 8
) (
  input  logic [W+2:0]  ext_in,
  input  logic [TW-1:0] tail_in,
  input  logic [1:0]    mode_sel,
  output logic [W-1:0]  mant_out,
  output logic          inc_carry
);
  localparam int FIELD_LSB = 3;
  localparam int GHI_POS   = 2;
  localparam int GLO_POS   = 1;
  localparam int STK_POS   = 0;

  logic [W-1:0] field;
  logic         g_hi;
  logic         g_lo;
  logic         sticky;
  mr_mode_e     mode;

  // R8: fixed positions within the extended mantissa.
  assign field = ext_in[W+2:FIELD_LSB];
  assign g_hi  = ext_in[GHI_POS];
  assign g_lo  = ext_in[GLO_POS];
  assign mode  = mr_mode_e'(mode_sel);

  mr_sticky #(.TW(TW)) u_sticky (
    .tail_in (tail_in),
    .low_bit (ext_in[STK_POS]),
    .sticky  (sticky)
  );

  mr_method #(.W(W)) u_method (
    .field  (field),
    .g_hi   (g_hi),
    .g_lo   (g_lo),
    .sticky (sticky),
    .mode   (mode),
    .res    (mant_out),
    .cout   (inc_carry)
  );

  always_comb begin
    if (mode_sel == 2'b11) begin
      p_rsvd_as_chop_r6: assert (mant_out == ext_in[W+2:FIELD_LSB] && !inc_carry);
    end
  end
endmodule

// File: tb/tb_mant_reduce.sv
module tb_mant_reduce;
  localparam int WB = 24;
  localparam int TB = 8;
  localparam int WS = 3;
  localparam int TS = 2;

  typedef struct packed {
    logic [31:0] exp_out;
    logic        exp_c;
    logic [1:0]  mode;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [WB+2:0] ext_b = '0;
  logic [TB-1:0] tail_b = '0;
  logic [1:0]    mode_b = 2'b00;
  logic [WB-1:0] out_b;
  logic          c_b;

  logic [WS+2:0] ext_s = '0;
  logic [TS-1:0] tail_s = '0;
  logic [1:0]    mode_s = 2'b00;
  logic [WS-1:0] out_s;
  logic          c_s;

  mant_reduce #(.W(WB), .TW(TB)) dut (
    .ext_in(ext_b), .tail_in(tail_b), .mode_sel(mode_b),
    .mant_out(out_b), .inc_carry(c_b));

  mant_reduce #(.W(WS), .TW(TS)) dut_small (
    .ext_in(ext_s), .tail_in(tail_s), .mode_sel(mode_s),
    .mant_out(out_s), .inc_carry(c_s));

  item_t qb[$];
  item_t qs[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference: integer arithmetic on a 32-bit value of width w.
  function automatic logic [32:0] model(input int w, input logic [31:0] f,
                                        input logic gh, input logic gl,
                                        input logic st, input logic [1:0] m);
    logic [32:0] s;
    logic [31:0] lim;
    lim = 32'h1 << w;
    if (m == 2'b01) return {1'b0, (gh | gl | st) ? (f | 32'h1) : f};
    if (m == 2'b10) begin
      s = {1'b0, f} + (gh ? 33'd1 : 33'd0);
      if (s[31:0] >= lim) return {1'b1, 32'h1 << (w - 1)};
      return {1'b0, s[31:0]};
    end
    return {1'b0, f};
  endfunction

  function automatic string tag(input logic [1:0] m, input logic c);
    if (m == 2'b11) return "R6";
    if (m == 2'b10) return c ? "R4/R5" : "R3";
    if (m == 2'b01) return "R2/R7";
    return "R1";
  endfunction

  task automatic drive_big(input logic [WB+2:0] e, input logic [TB-1:0] t,
                           input logic [1:0] m);
    item_t it;
    logic [32:0] r;
    @(posedge clk); #1;
    ext_b = e; tail_b = t; mode_b = m;
    r = model(WB, {8'h0, e[WB+2:3]}, e[2], e[1], e[0] | (|t), m);
    it.exp_out = r[31:0]; it.exp_c = r[32]; it.mode = m;
    qb.push_back(it);
  endtask

  task automatic drive_small(input logic [WS+2:0] e, input logic [TS-1:0] t,
                             input logic [1:0] m);
    item_t it;
    logic [32:0] r;
    @(posedge clk); #1;
    ext_s = e; tail_s = t; mode_s = m;
    r = model(WS, {29'h0, e[5:3]}, e[2], e[1], e[0] | (|t), m);
    it.exp_out = r[31:0]; it.exp_c = r[32]; it.mode = m;
    qs.push_back(it);
  endtask

  // Monitor: compares half a period after each drive.
  initial begin
    forever begin
      @(negedge clk);
      if (qb.size() > 0) begin
        item_t it;
        it = qb.pop_front();
        checks++;
        if ({c_b, 8'h0, out_b} !== {it.exp_c, it.exp_out}) begin
          fails++;
          $display("FAIL %s big: got c=%0b out=%h exp c=%0b out=%h",
                   tag(it.mode, it.exp_c), c_b, out_b, it.exp_c, it.exp_out[WB-1:0]);
        end
      end
      if (qs.size() > 0) begin
        item_t it;
        it = qs.pop_front();
        checks++;
        if ({c_s, 29'h0, out_s} !== {it.exp_c, it.exp_out}) begin
          fails++;
          $display("FAIL %s small: got c=%0b out=%h exp c=%0b out=%h",
                   tag(it.mode, it.exp_c), c_s, out_s, it.exp_c, it.exp_out[WS-1:0]);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset-state check: all-zero inputs give zero output, no carry (R1).
    drive_big('0, '0, 2'b00);
    // R4/R5: all-ones field with high guard set overflows in round mode.
    drive_big({{WB{1'b1}}, 3'b100}, '0, 2'b10);
    // R3: all-ones field, only low guard and sticky set: no change.
    drive_big({{WB{1'b1}}, 3'b011}, 8'hFF, 2'b10);
    // R5: same overflow pattern in jam and chop gives no carry.
    drive_big({{WB{1'b1}}, 3'b100}, '0, 2'b01);
    drive_big({{WB{1'b1}}, 3'b100}, '0, 2'b00);
    // R7: a lone tail bit makes jam set the LSB.
    drive_big({24'hABCDE0, 3'b000}, 8'h80, 2'b01);
    drive_big({24'hABCDE0, 3'b000}, 8'h01, 2'b01);
    drive_big({24'hABCDE0, 3'b000}, 8'h00, 2'b01);
    // R6: reserved code acts as chop.
    drive_big({24'h7FFFFF, 3'b111}, 8'hFF, 2'b11);
    // R8: each position alone in round mode.
    drive_big({24'h000010, 3'b100}, '0, 2'b10);
    drive_big({24'h000010, 3'b010}, '0, 2'b10);
    drive_big({24'h000010, 3'b001}, '0, 2'b10);
    // Random vectors at full width.
    for (int i = 0; i < 2000; i++) begin
      drive_big({$urandom, $urandom}, 8'($urandom & ((i % 3 == 0) ? 0 : 32'hFF)),
                2'($urandom));
    end
    // Exhaustive sweep at reduced width (R1..R8).
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 64; e++)
        for (int t = 0; t < 4; t++)
          drive_small(6'(e), 2'(t), 2'(m));
    while (qb.size() > 0 || qs.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule